// File: doc/BRIEF.md
# Registered Command Buffer with Delayed Parity Check

This block sits between a memory controller and a bank of memory devices on a module. It registers the address/command bus, the clock-enable and on-die-termination controls and the chip selects on the rising clock edge. It then drives each registered signal to two output groups, A and B, so that the two halves of the module each see a lightly loaded copy.

A mode input picks one of two chip-select arrangements. In paired mode, two chip-select inputs each feed both the A and the B output. In quad mode, four chip-select inputs each feed one output.

The address/command bits also feed a parity checker. The expected parity bit for a cycle's data reaches the block one clock later. When the two disagree, an active-low error flag drops for one cycle. The clock-enable, termination and chip-select lines are outside the check.

Top module: `cmd_reg_buf`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next outputs are as follows: `ac_a`, `ac_b`, `cke_a`, `cke_b`, `odt_a` and `odt_b` are all zero, `cs_a` and `cs_b` are all ones (inactive), and `err_n` is high.
- R2: After each rising edge out of reset, `ac_a` and `ac_b` both equal the `ac_in` value sampled at that edge.
- R3: After each rising edge out of reset, `cke_a`/`cke_b` equal the sampled `cke_in`, and `odt_a`/`odt_b` equal the sampled `odt_in`.
- R4: With `cs_pair_mode` high at an edge, `cs_a[i]` and `cs_b[i]` both take `cs_in[i]` for i = 0,1, and `cs_in[3:2]` has no effect on any output.
- R5: With `cs_pair_mode` low at an edge, `cs_a` takes `cs_in[1:0]` and `cs_b` takes `cs_in[3:2]`.
- R6: Call the XOR of all `ac_in` bits sampled at edge N the computed parity. If `par_in` sampled at edge N+1 differs from it, `err_n` is low during the cycle after edge N+1.
- R7: `err_n` is high whenever the comparison made at the previous edge matched. Each mismatch gives exactly one low cycle, so consecutive mismatches give consecutive low cycles.
- R8: `cke_in`, `odt_in` and `cs_in` do not enter the parity. Changing them never changes `err_n`.
- R9: The comparison made at the first edge after reset is released is ignored, so `err_n` stays high whatever `par_in` is at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_pair_mode | input | 1 | 1 = two chip selects duplicated, 0 = four independent chip selects |
| ac_in | input | AC_W | Address and command bits |
| cke_in | input | CTL_W | Clock-enable controls |
| odt_in | input | CTL_W | On-die-termination controls |
| cs_in | input | CS_W | Chip selects, active low |
| par_in | input | 1 | Parity for the previous cycle's `ac_in` |
| ac_a | output | AC_W | Address/command copy A |
| ac_b | output | AC_W | Address/command copy B |
| cke_a | output | CTL_W | Clock-enable copy A |
| cke_b | output | CTL_W | Clock-enable copy B |
| odt_a | output | CTL_W | Termination copy A |
| odt_b | output | CTL_W | Termination copy B |
| cs_a | output | CS_W/2 | Chip-select outputs, group A |
| cs_b | output | CS_W/2 | Chip-select outputs, group B |
| err_n | output | 1 | Parity error flag, active low, one cycle per mismatch |

## Verification
Two cases are hard to reach from the ports. The first is the comparison at the first edge after reset release, where no data has yet been captured. The stimulus drives a deliberately wrong `par_in` at exactly that edge and expects `err_n` to stay high. The second is proving that the control lines are outside the parity. A phase holds `ac_in` and `par_in` at a matching pair while `cke_in`, `odt_in` and `cs_in` toggle every cycle, and `err_n` must never drop. A later phase sends runs of wrong parity back to back, so that low cycles sit next to each other rather than being stretched by the flag logic.

// File: rtl/cmd_reg_pkg.sv
package cmd_reg_pkg;

   typedef enum logic {
      CS_QUAD = 1'b0,
      CS_PAIR = 1'b1
   } cs_mode_e;

   localparam logic CS_IDLE = 1'b1;

endpackage

// File: rtl/cmd_fanout_reg.sv
module cmd_fanout_reg #(
   parameter int   W       = 8,
   parameter logic RST_BIT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q_a,
   output logic [W-1:0] q_b
);

   localparam logic [W-1:0] RST_VEC = {W{RST_BIT}};

   generate
      if (W < 1) begin : g_bad_w
         $error("cmd_fanout_reg: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_a <= RST_VEC;
         q_b <= RST_VEC;
      end else begin
         q_a <= d;
         q_b <= d;
      end
   end

endmodule

// File: rtl/cmd_cs_router.sv
module cmd_cs_router
   import cmd_reg_pkg::*;
#(
   parameter int CS_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pair_mode,
   input  logic [CS_W-1:0]   cs_in,
   output logic [CS_W/2-1:0] cs_a,
   output logic [CS_W/2-1:0] cs_b
);

   localparam int HALF = CS_W / 2;

   generate
      if ((CS_W < 2) || (CS_W % 2 != 0)) begin : g_bad_cs
         $error("cmd_cs_router: CS_W must be even and at least 2");
      end
   endgenerate

   logic [HALF-1:0] nxt_a;
   logic [HALF-1:0] nxt_b;

   genvar gi;
   generate
      for (gi = 0; gi < HALF; gi++) begin : g_lane
         assign nxt_a[gi] = cs_in[gi];
         assign nxt_b[gi] = (cs_mode_e'(pair_mode) == CS_PAIR) ? cs_in[gi]
                                                               : cs_in[gi + HALF];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_a <= {HALF{CS_IDLE}};
         cs_b <= {HALF{CS_IDLE}};
      end else begin
         cs_a <= nxt_a;
         cs_b <= nxt_b;
      end
   end

endmodule

// File: rtl/cmd_parity_chk.sv
module cmd_parity_chk #(
   parameter int AC_W = 22
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AC_W-1:0] ac_in,
   input  logic            par_in,
   output logic            err_n
);

   generate
      if (AC_W < 1) begin : g_bad_ac
         $error("cmd_parity_chk: AC_W must be at least 1");
      end
   endgenerate

   logic calc_par;
   logic held_par;
   logic held_vld;

   assign calc_par = ^ac_in;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_par <= 1'b0;
         held_vld <= 1'b0;
         err_n    <= 1'b1;
      end else begin
         held_par <= calc_par;
         held_vld <= 1'b1;
         err_n    <= !(held_vld && (par_in != held_par));
      end
   end

endmodule

// File: rtl/cmd_reg_buf.sv
module cmd_reg_buf #(
   parameter int AC_W  = 22,
   parameter int CTL_W = 2,
   parameter int CS_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_pair_mode,
   input  logic [AC_W-1:0]   ac_in,
   input  logic [CTL_W-1:0]  cke_in,
   input  logic [CTL_W-1:0]  odt_in,
   input  logic [CS_W-1:0]   cs_in,
   input  logic              par_in,
   output logic [AC_W-1:0]   ac_a,
   output logic [AC_W-1:0]   ac_b,
   output logic [CTL_W-1:0]  cke_a,
   output logic [CTL_W-1:0]  cke_b,
   output logic [CTL_W-1:0]  odt_a,
   output logic [CTL_W-1:0]  odt_b,
   output logic [CS_W/2-1:0] cs_a,
   output logic [CS_W/2-1:0] cs_b,
   output logic              err_n
);

   generate
      if (CTL_W < 1) begin : g_bad_ctl
         $error("cmd_reg_buf: CTL_W must be at least 1");
      end
   endgenerate

   cmd_fanout_reg #(.W(AC_W), .RST_BIT(1'b0)) u_ac (
      .clk(clk), .rst_n(rst_n), .d(ac_in), .q_a(ac_a), .q_b(ac_b)
   );

   cmd_fanout_reg #(.W(CTL_W), .RST_BIT(1'b0)) u_cke (
      .clk(clk), .rst_n(rst_n), .d(cke_in), .q_a(cke_a), .q_b(cke_b)
   );

   cmd_fanout_reg #(.W(CTL_W), .RST_BIT(1'b0)) u_odt (
      .clk(clk), .rst_n(rst_n), .d(odt_in), .q_a(odt_a), .q_b(odt_b)
   );

   cmd_cs_router #(.CS_W(CS_W)) u_cs (
      .clk(clk), .rst_n(rst_n), .pair_mode(cs_pair_mode),
      .cs_in(cs_in), .cs_a(cs_a), .cs_b(cs_b)
   );

   cmd_parity_chk #(.AC_W(AC_W)) u_par (
      .clk(clk), .rst_n(rst_n), .ac_in(ac_in), .par_in(par_in), .err_n(err_n)
   );

endmodule

// File: rtl/cmd_reg_buf_chk.sv
module cmd_reg_buf_chk #(
   parameter int AC_W  = 22,
   parameter int CTL_W = 2,
   parameter int CS_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_pair_mode,
   input logic [AC_W-1:0]   ac_in,
   input logic [CTL_W-1:0]  cke_in,
   input logic [CTL_W-1:0]  odt_in,
   input logic [CS_W-1:0]   cs_in,
   input logic              par_in,
   input logic [AC_W-1:0]   ac_a,
   input logic [AC_W-1:0]   ac_b,
   input logic [CTL_W-1:0]  cke_a,
   input logic [CTL_W-1:0]  cke_b,
   input logic [CTL_W-1:0]  odt_a,
   input logic [CTL_W-1:0]  odt_b,
   input logic [CS_W/2-1:0] cs_a,
   input logic [CS_W/2-1:0] cs_b,
   input logic              err_n
);

   localparam int HALF = CS_W / 2;

   AST_RESET_STATE: assert property (@(posedge clk)
      !rst_n |=> (ac_a == '0) && (ac_b == '0) && (cke_a == '0) && (odt_b == '0)
                 && (cs_a == {HALF{1'b1}}) && (cs_b == {HALF{1'b1}}) && err_n); // R1

   AST_AC_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (ac_a == $past(ac_in)) && (ac_b == $past(ac_in))); // R2

   AST_CTL_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cke_a == $past(cke_in)) && (cke_b == $past(cke_in))
               && (odt_a == $past(odt_in)) && (odt_b == $past(odt_in))); // R3

   AST_CS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      cs_pair_mode |=> (cs_b == cs_a) && (cs_a == $past(cs_in[HALF-1:0]))); // R4

   AST_CS_QUAD: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_pair_mode |=> (cs_b == $past(cs_in[CS_W-1:HALF]))); // R5

   AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !err_n |-> ($past(par_in) != $past(^ac_in, 2))); // R6

   AST_ERR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |=> err_n); // R9

endmodule

bind cmd_reg_buf cmd_reg_buf_chk #(.AC_W(AC_W), .CTL_W(CTL_W), .CS_W(CS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_pair_mode(cs_pair_mode), .ac_in(ac_in),
   .cke_in(cke_in), .odt_in(odt_in), .cs_in(cs_in), .par_in(par_in),
   .ac_a(ac_a), .ac_b(ac_b), .cke_a(cke_a), .cke_b(cke_b), .odt_a(odt_a),
   .odt_b(odt_b), .cs_a(cs_a), .cs_b(cs_b), .err_n(err_n)
);

// File: tb/cmd_reg_buf_tb.sv
module cmd_reg_buf_tb;

   localparam int AC_W  = 22;
   localparam int CTL_W = 2;
   localparam int CS_W  = 4;
   localparam int HALF  = CS_W / 2;

   typedef struct {
      logic [AC_W-1:0]  ac;
      logic [CTL_W-1:0] cke;
      logic [CTL_W-1:0] odt;
      logic [HALF-1:0]  csa;
      logic [HALF-1:0]  csb;
      logic             err_n;
      int               tag;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cs_pair_mode = 1'b1;
   logic [AC_W-1:0]   ac_in = '0;
   logic [CTL_W-1:0]  cke_in = '0;
   logic [CTL_W-1:0]  odt_in = '0;
   logic [CS_W-1:0]   cs_in = '1;
   logic              par_in = 1'b0;
   logic [AC_W-1:0]   ac_a, ac_b;
   logic [CTL_W-1:0]  cke_a, cke_b, odt_a, odt_b;
   logic [HALF-1:0]   cs_a, cs_b;
   logic              err_n;

   int total = 0;
   int bad   = 0;
   int cycles = 0;
   bit done = 1'b0;

   exp_t sb[$];
   logic m_vld = 1'b0;
   logic m_par = 1'b0;

   always #2.5 clk = ~clk;

   cmd_reg_buf #(.AC_W(AC_W), .CTL_W(CTL_W), .CS_W(CS_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .cs_pair_mode(cs_pair_mode), .ac_in(ac_in),
      .cke_in(cke_in), .odt_in(odt_in), .cs_in(cs_in), .par_in(par_in),
      .ac_a(ac_a), .ac_b(ac_b), .cke_a(cke_a), .cke_b(cke_b),
      .odt_a(odt_a), .odt_b(odt_b), .cs_a(cs_a), .cs_b(cs_b), .err_n(err_n)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
      end
   endtask

   // tag: 1 = reset item, 2 = pair mode, 3 = quad mode
   task automatic drive(input logic r, input logic mode, input logic [AC_W-1:0] ac,
                        input logic [CTL_W-1:0] ck, input logic [CTL_W-1:0] od,
                        input logic [CS_W-1:0] cs, input logic p);
      exp_t e;
      @(negedge clk);
      rst_n = r; cs_pair_mode = mode; ac_in = ac; cke_in = ck; odt_in = od;
      cs_in = cs; par_in = p;
      if (!r) begin
         e.ac = '0; e.cke = '0; e.odt = '0; e.csa = '1; e.csb = '1;
         e.err_n = 1'b1; e.tag = 1;
         m_vld = 1'b0; m_par = 1'b0;
      end else begin
         e.ac = ac; e.cke = ck; e.odt = od;
         e.csa = cs[HALF-1:0];
         e.csb = mode ? cs[HALF-1:0] : cs[CS_W-1:HALF];
         e.err_n = !(m_vld && (p != m_par));
         e.tag = mode ? 2 : 3;
         m_par = ^ac; m_vld = 1'b1;
      end
      sb.push_back(e);
   endtask

   always @(posedge clk) begin
      #1;
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         if (e.tag == 1) begin
            chk((ac_a == e.ac) && (ac_b == e.ac) && (cke_a == '0) && (odt_b == '0),
                "R1 data", {ac_a, ac_b}, '0);
            chk((cs_a == e.csa) && (cs_b == e.csb) && err_n, "R1 cs/err",
                {cs_a, cs_b, err_n}, {e.csa, e.csb, 1'b1});
         end else begin
            chk((ac_a == e.ac) && (ac_b == e.ac), "R2", {ac_a, ac_b}, {e.ac, e.ac});
            chk((cke_a == e.cke) && (cke_b == e.cke) && (odt_a == e.odt) && (odt_b == e.odt),
                "R3", {cke_a, cke_b, odt_a, odt_b}, {e.cke, e.cke, e.odt, e.odt});
            chk((cs_a == e.csa) && (cs_b == e.csb), (e.tag == 2) ? "R4" : "R5",
                {cs_a, cs_b}, {e.csa, e.csb});
            chk(err_n == e.err_n, "R6/R7/R8/R9 err_n", err_n, e.err_n);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         bad++; total++;
         $display("FAIL watchdog act=%0d exp=<100000", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [AC_W-1:0] a;
      // R1: reset with busy inputs
      for (int i = 0; i < 3; i++) drive(1'b0, 1'b1, '1, '1, '1, 4'h0, 1'b1);
      // R9: first compare after release with wrong parity
      a = 22'h2A5A5A;
      drive(1'b1, 1'b1, a, 2'b01, 2'b10, 4'b0101, ~(^a));
      drive(1'b1, 1'b1, a, 2'b01, 2'b10, 4'b0101, ~(^a));   // R6 mismatch
      drive(1'b1, 1'b1, a, 2'b01, 2'b10, 4'b0101, ^a);      // match
      // R8: controls toggle, ac and parity held matching
      for (int i = 0; i < 16; i++)
         drive(1'b1, i[0], a, 2'(i), 2'(i + 1), 4'(i * 5), ^a);
      // R4 / R5: chip-select patterns in both modes
      for (int i = 0; i < 16; i++) drive(1'b1, 1'b1, a, '0, '0, 4'(i), ^a);
      for (int i = 0; i < 16; i++) drive(1'b1, 1'b0, a, '0, '0, 4'(i), ^a);
      // R7: back-to-back mismatches then recovery
      for (int i = 0; i < 4; i++) begin
         logic [AC_W-1:0] prev;
         prev = a;
         a = AC_W'($urandom);
         drive(1'b1, 1'b0, a, '0, '0, 4'hF, ~(^prev));
      end
      drive(1'b1, 1'b0, a, '0, '0, 4'hF, ^a);
      // R2 / R6: random traffic with random parity, then reset mid-run
      for (int i = 0; i < 200; i++) begin
         logic [AC_W-1:0] prev;
         prev = a;
         a = AC_W'($urandom);
         drive(1'b1, 1'($urandom), a, 2'($urandom), 2'($urandom), 4'($urandom),
               ($urandom % 3 == 0) ? ~(^prev) : ^prev);
      end
      drive(1'b0, 1'b1, a, '1, '1, 4'h0, 1'b0);
      drive(1'b1, 1'b1, 22'h000001, '0, '0, 4'h3, 1'b1);    // R9 again
      drive(1'b1, 1'b1, 22'h000001, '0, '0, 4'h3, 1'b0);    // mismatch
      drive(1'b1, 1'b1, 22'h000001, '0, '0, 4'h3, 1'b1);
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule